// File: doc/BRIEF.md
# Temperature Sensor Serial Register Interface

This block is the two-wire serial slave that sits in front of a module temperature sensor's bank of 16-bit registers. A bus master first addresses the block and writes a pointer byte. It can then either write a 16-bit value into the selected register or issue a repeated START and read that register back. All data moves high byte first. The block never drives the data line high. It only asserts an output enable that pulls the open-drain line low, for acknowledges and for read data bits that are zero.

The configuration register and the three temperature limit registers (upper alarm bound, lower alarm bound, critical limit) are held here and fed to the neighbouring alarm logic. Each committed write also raises a one-cycle strobe that carries the register code. The alarm logic returns the live temperature word and the event status flag, and both are presented on reads. The serial clock and data inputs are sampled through two-flop synchronizers on the system clock. The system clock must run far faster than the 10 to 100 kHz serial clock.

Top module: `tsense_smbus_regif`

## Requirements
- R1: After reset the SDA enable is low, the configuration and all three limit outputs are 0x0000, and a read of register code 0 returns 0x0001.
- R2: The block acknowledges only the address byte {0011, strap_i[2:0], rw}, with rw=1 for a read. For any other address it leaves SDA released for the rest of that transfer.
- R3: In a write transfer, the first data byte is the pointer, and its bits 2:0 select the register: 0 capability, 1 configuration, 2 upper bound, 3 lower bound, 4 critical limit, 5 temperature. Every byte of an addressed write transfer is acknowledged.
- R4: The second and third data bytes form a 16-bit word, high byte first, and the word is committed when the third byte completes. A commit to codes 1 to 4 updates that register and pulses wr_stb_o for one cycle with wr_sel_o equal to the code. Any later byte in the same transfer changes nothing.
- R5: A read transfer returns the selected register high byte first and then the low byte. The 16-bit value is captured when the read begins, so a change in the live value between the two bytes does not split the word.
- R6: Writes to codes 0, 5, 6 and 7 change no register and produce no strobe. Codes 6 and 7 read as 0x0000, and code 5 reads temp_i unchanged.
- R7: The configuration register stores only bits 10:5 and 3:0 of a written word. Bits 15:11 read as zero, and bit 4 reads evt_status_i. The limit registers store only bits 12:2 of a written word and read zero elsewhere.
- R8: A repeated START at any point starts a new address phase, and a read after a pointer write plus repeated START uses the new pointer.
- R9: While the master acknowledges, read bytes keep alternating high, low, high, low from the same captured word. After a master NACK, SDA stays released until the next START.
- R10: A STOP in the middle of a byte returns the block to idle, and a partly received word is not committed.
- R11: The SDA enable changes only while the synchronized SCL is low, except at the cycle after a START or STOP is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pulls the data line low when high |
| strap_i | input | 3 | Board strap bits forming the low address bits |
| temp_i | input | 16 | Live temperature word from the alarm logic |
| evt_status_i | input | 1 | Live event status flag from the alarm logic |
| cfg_o | output | 16 | Stored configuration register |
| lim_hi_o | output | 16 | Stored upper alarm bound |
| lim_lo_o | output | 16 | Stored lower alarm bound |
| lim_crit_o | output | 16 | Stored critical limit |
| wr_stb_o | output | 1 | One-cycle strobe for a committed register write |
| wr_sel_o | output | 3 | Register code of the committed write |

## Verification
The hardest case to reach is a read word whose source changes between its two bytes. The live temperature input is changed after the high byte has been clocked out and acknowledged, and the low byte must still come from the earlier value. A second hard case is a STOP that lands after only four bits of the low data byte. The bench drives a partial byte and then a STOP, and then confirms that the limit output and the strobe count are unchanged. Repeated STARTs, wrong addresses, a strap change and a long acknowledged read are each built as their own directed bit-level sequences on a modelled open-drain line.

// File: rtl/smb_pkg.sv
// Package: shared constants and types for the sensor serial register interface.
// Assumes a 3-bit register pointer and 16-bit registers moved as two bytes.
package smb_pkg;
    localparam int          REG_W     = 16;
    localparam int          PTR_W     = 3;
    localparam logic [3:0]  ADDR_PFX  = 4'b0011;
    localparam logic [15:0] CAP_VALUE = 16'h0001;
    localparam logic [15:0] CFG_WMASK = 16'h07EF;
    localparam logic [15:0] LIM_MASK  = 16'h1FFC;
    localparam int          NUM_LIM   = 3;

    localparam logic [PTR_W-1:0] PTR_CAP  = 3'd0;
    localparam logic [PTR_W-1:0] PTR_CFG  = 3'd1;
    localparam logic [PTR_W-1:0] PTR_HI   = 3'd2;
    localparam logic [PTR_W-1:0] PTR_LO   = 3'd3;
    localparam logic [PTR_W-1:0] PTR_CRIT = 3'd4;
    localparam logic [PTR_W-1:0] PTR_TEMP = 3'd5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_RACK
    } link_state_t;
endpackage

// File: rtl/smb_sync.sv
// Module: smb_sync
// Brings SCL and SDA into the clock domain through a flop chain and derives
// edge and bus-condition pulses from the synchronized values.
// Assumes the system clock is many times faster than SCL; idle bus is high.
module smb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic [NSIG-1:0] prev_q;

    assign raw = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < NSIG; g++) begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift the raw line through the synchronizer flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain_q[STAGES-1];
        end
    endgenerate

    // Keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= synced;
    end

    assign scl_s     = synced[1];
    assign sda_s     = synced[0];
    assign scl_rise  = synced[1] & ~prev_q[1];
    assign scl_fall  = ~synced[1] & prev_q[1];
    assign start_det = synced[1] & prev_q[1] & prev_q[0] & ~synced[0];
    assign stop_det  = synced[1] & prev_q[1] & ~prev_q[0] & synced[0];
endmodule

// File: rtl/smb_link.sv
// Module: smb_link
// Byte-level slave state machine: address match, acknowledges, received
// write bytes with their index, and read bytes shifted out MSB first.
// Assumes synchronized inputs and one-cycle edge/condition pulses.
module smb_link
    import smb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s_i,
    input  logic             sda_s_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [2:0]       strap_i,
    input  logic [REG_W-1:0] rd_word_i,
    output logic             sda_oe_o,
    output logic             wr_vld_o,
    output logic [1:0]       wr_idx_o,
    output logic [7:0]       wr_data_o
);
    link_state_t       state_q;
    logic [2:0]        bitcnt_q;
    logic [7:0]        shreg_q;
    logic [7:0]        txsh_q;
    logic [REG_W-1:0]  snap_q;
    logic              got8_q;
    logic              rw_q;
    logic              next_hi_q;
    logic              mack_q;
    logic [1:0]        byte_idx_q;
    logic [6:0]        my_addr;
    logic [7:0]        next_tx;

    assign my_addr = {ADDR_PFX, strap_i};
    assign next_tx = next_hi_q ? snap_q[15:8] : snap_q[7:0];

    // Main bus sequencer: shifts bits, issues ACKs and drives read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            txsh_q     <= '0;
            snap_q     <= '0;
            got8_q     <= 1'b0;
            rw_q       <= 1'b0;
            next_hi_q  <= 1'b0;
            mack_q     <= 1'b0;
            byte_idx_q <= '0;
            sda_oe_o   <= 1'b0;
            wr_vld_o   <= 1'b0;
            wr_idx_o   <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_vld_o <= 1'b0;
            if (stop_i) begin
                state_q  <= S_IDLE;
                sda_oe_o <= 1'b0;
                got8_q   <= 1'b0;
            end else if (start_i) begin
                state_q  <= S_ADDR;
                sda_oe_o <= 1'b0;
                got8_q   <= 1'b0;
                bitcnt_q <= '0;
            end else begin
                case (state_q)
                    S_ADDR: begin
                        if (scl_rise_i) begin
                            shreg_q  <= {shreg_q[6:0], sda_s_i};
                            bitcnt_q <= bitcnt_q + 3'd1;
                            if (bitcnt_q == 3'd7) got8_q <= 1'b1;
                        end else if (scl_fall_i && got8_q) begin
                            got8_q <= 1'b0;
                            if (shreg_q[7:1] == my_addr) begin
                                sda_oe_o <= 1'b1;
                                rw_q     <= shreg_q[0];
                                state_q  <= S_AACK;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end
                    end
                    S_AACK: begin
                        if (scl_fall_i) begin
                            bitcnt_q <= '0;
                            if (rw_q) begin
                                snap_q    <= rd_word_i;
                                txsh_q    <= rd_word_i[15:8];
                                sda_oe_o  <= ~rd_word_i[15];
                                next_hi_q <= 1'b0;
                                state_q   <= S_RDATA;
                            end else begin
                                sda_oe_o   <= 1'b0;
                                byte_idx_q <= '0;
                                state_q    <= S_WDATA;
                            end
                        end
                    end
                    S_WDATA: begin
                        if (scl_rise_i) begin
                            shreg_q  <= {shreg_q[6:0], sda_s_i};
                            bitcnt_q <= bitcnt_q + 3'd1;
                            if (bitcnt_q == 3'd7) got8_q <= 1'b1;
                        end else if (scl_fall_i && got8_q) begin
                            got8_q    <= 1'b0;
                            sda_oe_o  <= 1'b1;
                            wr_vld_o  <= 1'b1;
                            wr_idx_o  <= byte_idx_q;
                            wr_data_o <= shreg_q;
                            if (byte_idx_q != 2'd3) byte_idx_q <= byte_idx_q + 2'd1;
                            state_q   <= S_WACK;
                        end
                    end
                    S_WACK: begin
                        if (scl_fall_i) begin
                            sda_oe_o <= 1'b0;
                            state_q  <= S_WDATA;
                        end
                    end
                    S_RDATA: begin
                        if (scl_rise_i) begin
                            bitcnt_q <= bitcnt_q + 3'd1;
                            if (bitcnt_q == 3'd7) got8_q <= 1'b1;
                        end else if (scl_fall_i) begin
                            if (got8_q) begin
                                got8_q   <= 1'b0;
                                sda_oe_o <= 1'b0;
                                state_q  <= S_RACK;
                            end else begin
                                txsh_q   <= {txsh_q[6:0], 1'b0};
                                sda_oe_o <= ~txsh_q[6];
                            end
                        end
                    end
                    S_RACK: begin
                        if (scl_rise_i) begin
                            mack_q <= ~sda_s_i;
                        end else if (scl_fall_i) begin
                            if (mack_q) begin
                                txsh_q    <= next_tx;
                                sda_oe_o  <= ~next_tx[7];
                                next_hi_q <= ~next_hi_q;
                                bitcnt_q  <= '0;
                                state_q   <= S_RDATA;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: when the sequencer is idle the line is never pulled.
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !sda_oe_o);

    // R11: the data enable only moves while SCL is low, or on a bus condition.
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> (!scl_s_i || $past(start_i || stop_i)));

    // R2: an address acknowledge follows only a matching address byte.
    p_ack_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_AACK) && ($past(state_q) == S_ADDR))
            |-> ($past(shreg_q[7:1]) == {ADDR_PFX, $past(strap_i)}));
endmodule

// File: rtl/smb_regbank.sv
// Module: smb_regbank
// Holds the pointer, configuration and limit registers, commits 16-bit words
// and presents the word selected by the pointer for reads.
// Assumes byte index 0 is the pointer, 1 the high byte and 2 the low byte.
module smb_regbank
    import smb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_vld_i,
    input  logic [1:0]       wr_idx_i,
    input  logic [7:0]       wr_data_i,
    input  logic [REG_W-1:0] temp_i,
    input  logic             evt_status_i,
    output logic [REG_W-1:0] rd_word_o,
    output logic [REG_W-1:0] cfg_o,
    output logic [REG_W-1:0] lim_o [NUM_LIM],
    output logic             wr_stb_o,
    output logic [PTR_W-1:0] wr_sel_o
);
    logic [PTR_W-1:0] ptr_q;
    logic [7:0]       hold_q;
    logic             commit;
    logic [REG_W-1:0] wword;
    logic             writable;

    assign commit   = wr_vld_i && (wr_idx_i == 2'd2);
    assign wword    = {hold_q, wr_data_i};
    assign writable = (ptr_q >= PTR_CFG) && (ptr_q <= PTR_CRIT);

    // Capture the pointer and the pending high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            hold_q <= '0;
        end else if (wr_vld_i) begin
            if (wr_idx_i == 2'd0) ptr_q  <= wr_data_i[PTR_W-1:0];
            if (wr_idx_i == 2'd1) hold_q <= wr_data_i;
        end
    end

    // Commit a full word into the configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cfg_o <= '0;
        else if (commit && ptr_q == PTR_CFG) cfg_o <= wword & CFG_WMASK;
    end

    generate
        for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
            // Commit a full word into limit register i.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lim_o[i] <= '0;
                else if (commit && ptr_q == PTR_W'(int'(PTR_HI) + i))
                    lim_o[i] <= wword & LIM_MASK;
            end

            // R4: a limit register moves only on a committed word.
            p_lim_by_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(lim_o[i]) |-> $past(commit));
        end
    endgenerate

    // Announce each committed write to the alarm logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb_o <= 1'b0;
            wr_sel_o <= '0;
        end else begin
            wr_stb_o <= commit && writable;
            if (commit) wr_sel_o <= ptr_q;
        end
    end

    // Select the word returned on reads.
    always_comb begin
        case (ptr_q)
            PTR_CAP:  rd_word_o = CAP_VALUE;
            PTR_CFG:  rd_word_o = (cfg_o & CFG_WMASK) | {11'd0, evt_status_i, 4'd0};
            PTR_HI:   rd_word_o = lim_o[0];
            PTR_LO:   rd_word_o = lim_o[1];
            PTR_CRIT: rd_word_o = lim_o[2];
            PTR_TEMP: rd_word_o = temp_i;
            default:  rd_word_o = '0;
        endcase
    end

    // R4: configuration changes only through a commit aimed at code 1.
    p_cfg_by_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(commit && ptr_q == PTR_CFG));

    // R4: the write strobe lasts a single cycle.
    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/tsense_smbus_regif.sv
// Module: tsense_smbus_regif
// Top of the sensor serial register interface: synchronizer, bus sequencer
// and register bank. Assumes an external open-drain pad driven by sda_oe.
module tsense_smbus_regif
    import smb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [2:0]  strap_i,
    input  logic [15:0] temp_i,
    input  logic        evt_status_i,
    output logic [15:0] cfg_o,
    output logic [15:0] lim_hi_o,
    output logic [15:0] lim_lo_o,
    output logic [15:0] lim_crit_o,
    output logic        wr_stb_o,
    output logic [2:0]  wr_sel_o
);
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_vld;
    logic [1:0]       wr_idx;
    logic [7:0]       wr_data;
    logic [REG_W-1:0] rd_word;
    logic [REG_W-1:0] lim [NUM_LIM];

    smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_link u_link (
        .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_det), .stop_i(stop_det), .strap_i(strap_i),
        .rd_word_i(rd_word), .sda_oe_o(sda_oe),
        .wr_vld_o(wr_vld), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
    );

    smb_regbank u_regs (
        .clk(clk), .rst_n(rst_n), .wr_vld_i(wr_vld), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .temp_i(temp_i), .evt_status_i(evt_status_i),
        .rd_word_o(rd_word), .cfg_o(cfg_o), .lim_o(lim),
        .wr_stb_o(wr_stb_o), .wr_sel_o(wr_sel_o)
    );

    assign lim_hi_o   = lim[0];
    assign lim_lo_o   = lim[1];
    assign lim_crit_o = lim[2];
endmodule

// File: tb/tsense_smbus_regif_tb.sv
module tsense_smbus_regif_tb;
    localparam int Q  = 8;
    localparam int WD = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b010;
    logic [15:0] temp = 16'h0000;
    logic        evt = 1'b0;
    logic        sda_oe, wr_stb;
    logic [2:0]  wr_sel;
    logic [15:0] cfg, lhi, llo, lcrit;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0, fails = 0, stb_cnt = 0, oe_viol = 0;
    logic [2:0] last_sel = '0;
    logic oe_prev = 1'b0;

    always #4 clk = ~clk;

    tsense_smbus_regif u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_i(strap), .temp_i(temp), .evt_status_i(evt), .cfg_o(cfg),
        .lim_hi_o(lhi), .lim_lo_o(llo), .lim_crit_o(lcrit),
        .wr_stb_o(wr_stb), .wr_sel_o(wr_sel)
    );

    // Strobe counter and SDA-edge monitor, sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin stb_cnt++; last_sel = wr_sel; end
        if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0; wq();
        end
        sda_m = ~mack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(); sda_m = 1'b1;
    endtask

    function automatic logic [7:0] abyte(input logic rw);
        return {4'b0011, strap, rw};
    endfunction

    task automatic reg_write(input logic [2:0] p, input logic [15:0] w, input string tag);
        logic a0, a1, a2, a3;
        bus_start();
        wr_byte(abyte(1'b0), a0); wr_byte({5'd0, p}, a1);
        wr_byte(w[15:8], a2); wr_byte(w[7:0], a3);
        bus_stop();
        chk({tag, " R3 write acks"}, {12'd0, a0, a1, a2, a3}, 16'h0000);
    endtask

    task automatic reg_read(input logic [2:0] p, output logic [15:0] w);
        logic a;
        logic [7:0] h, l;
        bus_start();
        wr_byte(abyte(1'b0), a); wr_byte({5'd0, p}, a);
        bus_start();
        wr_byte(abyte(1'b1), a);
        rd_byte(1'b1, h); rd_byte(1'b0, l);
        bus_stop();
        w = {h, l};
    endtask

    task automatic t_reset();
        logic [15:0] w;
        chk("R1 sda_oe", {15'd0, sda_oe}, 16'h0);
        chk("R1 cfg", cfg, 16'h0); chk("R1 hi", lhi, 16'h0);
        chk("R1 lo", llo, 16'h0); chk("R1 crit", lcrit, 16'h0);
        reg_read(3'd0, w);
        chk("R1 R8 capability read", w, 16'h0001);
    endtask

    task automatic t_bad_addr();
        logic a;
        int s0 = stb_cnt;
        bus_start();
        wr_byte({4'b0111, strap, 1'b0}, a);
        chk("R2 wrong address nack", {15'd0, a}, 16'h1);
        wr_byte(8'h01, a); wr_byte(8'hFF, a); wr_byte(8'hFF, a);
        bus_stop();
        chk("R2 ignored cfg", cfg, 16'h0);
        chk("R2 ignored strobe", 16'(stb_cnt - s0), 16'h0);
    endtask

    task automatic t_cfg();
        logic [15:0] w;
        int s0 = stb_cnt;
        reg_write(3'd1, 16'hFFFF, "cfg");
        chk("R7 cfg mask", cfg, 16'h07EF);
        chk("R4 strobe count", 16'(stb_cnt - s0), 16'h1);
        chk("R4 strobe sel", {13'd0, last_sel}, 16'h1);
        evt = 1'b1;
        reg_read(3'd1, w);
        chk("R7 cfg read evt=1", w, 16'h07FF);
        evt = 1'b0;
        reg_read(3'd1, w);
        chk("R7 cfg read evt=0", w, 16'h07EF);
    endtask

    task automatic t_limits();
        logic [15:0] w;
        reg_write(3'd2, 16'h1234, "hi");
        chk("R4 hi stored", lhi, 16'h1234);
        reg_write(3'd3, 16'hFFFF, "lo");
        chk("R7 lo mask", llo, 16'h1FFC);
        chk("R4 lo sel", {13'd0, last_sel}, 16'h3);
        reg_read(3'd3, w);
        chk("R5 lo read", w, 16'h1FFC);
        reg_read(3'd2, w);
        chk("R5 R8 hi read", w, 16'h1234);
    endtask

    task automatic t_extra_bytes();
        logic a0, a1, a2, a3, a4;
        int s0 = stb_cnt;
        bus_start();
        wr_byte(abyte(1'b0), a0); wr_byte(8'h04, a1);
        wr_byte(8'h0A, a2); wr_byte(8'hBC, a3); wr_byte(8'hFF, a4);
        bus_stop();
        chk("R3 all acked", {11'd0, a0, a1, a2, a3, a4}, 16'h0);
        chk("R4 crit stored", lcrit, 16'h0ABC);
        chk("R4 single strobe", 16'(stb_cnt - s0), 16'h1);
        chk("R4 crit sel", {13'd0, last_sel}, 16'h4);
    endtask

    task automatic t_readonly();
        logic [15:0] w;
        int s0 = stb_cnt;
        reg_write(3'd0, 16'hBEEF, "cap");
        reg_write(3'd5, 16'hBEEF, "temp");
        reg_write(3'd6, 16'hBEEF, "ptr6");
        reg_write(3'd7, 16'hBEEF, "ptr7");
        chk("R6 no strobe", 16'(stb_cnt - s0), 16'h0);
        reg_read(3'd0, w); chk("R6 cap unchanged", w, 16'h0001);
        reg_read(3'd6, w); chk("R6 ptr6 zero", w, 16'h0000);
        reg_read(3'd7, w); chk("R6 ptr7 zero", w, 16'h0000);
        temp = 16'hC1A8;
        reg_read(3'd5, w); chk("R6 temp read", w, 16'hC1A8);
        chk("R6 limits kept", lhi ^ llo ^ lcrit, 16'h1234 ^ 16'h1FFC ^ 16'h0ABC);
    endtask

    task automatic t_snapshot();
        logic a;
        logic [7:0] h, l;
        temp = 16'h1111;
        bus_start();
        wr_byte(abyte(1'b0), a); wr_byte(8'h05, a);
        bus_start();
        wr_byte(abyte(1'b1), a);
        rd_byte(1'b1, h);
        temp = 16'h2222;
        rd_byte(1'b0, l);
        bus_stop();
        chk("R5 snapshot word", {h, l}, 16'h1111);
    endtask

    task automatic t_stream();
        logic a;
        logic [7:0] b0, b1, b2, b3;
        bus_start();
        wr_byte(abyte(1'b0), a); wr_byte(8'h02, a);
        bus_start();
        wr_byte(abyte(1'b1), a);
        rd_byte(1'b1, b0); rd_byte(1'b1, b1); rd_byte(1'b1, b2); rd_byte(1'b0, b3);
        chk("R9 stream first", {b0, b1}, 16'h1234);
        chk("R9 stream repeat", {b2, b3}, 16'h1234);
        wq(2);
        chk("R9 released after nack", {15'd0, sda_oe}, 16'h0);
        bus_stop();
    endtask

    task automatic t_stop_mid();
        logic a;
        int s0 = stb_cnt;
        bus_start();
        wr_byte(abyte(1'b0), a); wr_byte(8'h02, a); wr_byte(8'h05, a);
        send_bits(8'h55, 4);
        bus_stop();
        chk("R10 hi kept", lhi, 16'h1234);
        chk("R10 no strobe", 16'(stb_cnt - s0), 16'h0);
    endtask

    task automatic t_strap();
        logic a;
        logic [15:0] w;
        strap = 3'b101;
        reg_read(3'd0, w);
        chk("R2 new strap read", w, 16'h0001);
        bus_start();
        wr_byte({4'b0011, 3'b010, 1'b0}, a);
        bus_stop();
        chk("R2 old strap nack", {15'd0, a}, 16'h1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_bad_addr();
        t_cfg();
        t_limits();
        t_extra_bytes();
        t_readonly();
        t_snapshot();
        t_stream();
        t_stop_mid();
        t_strap();
        chk("R11 sda edges while scl high", 16'(oe_viol), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule